// File: doc/BRIEF.md
# Multi-Format Sample Word Packer

The packer collects raw samples arriving one per strobe and assembles them into 32-bit words for a memory transfer path. A 3-bit format select sets how many samples share a word: four 8-bit samples, three 10-bit samples packed densely, two 10-bit samples each widened to 16 bits, two 16-bit samples, or one 20-bit sample. The earliest sample of a word always lands in the least-significant field. A completed word appears with a one-cycle valid pulse.

Alongside packing, the block turns a programmed threshold (a sample count per chunk) into the number of words that chunk yields under the current format. The downstream transfer engine uses that number as its transfer length. A qualifying flag tells whether the threshold divides exactly into a non-zero, even word count. A flush strobe, or any change of the format select, throws away a partly filled word and restarts at the first field.

Top module: `sample_word_packer`

## Requirements
- R1: While rst_ni is low and after it rises with no sample accepted, word_valid_o is 0, chunk_words_o is 0 and chunk_ok_o is 0.
- R2: Format code 0 packs four samples per word: sample k (k = 0..3, in arrival order) takes bits 8k+7:8k from its data bits 7:0; word_valid_o is high for exactly the one cycle after the fourth sample is taken.
- R3: Format code 1 packs three samples per word: sample k takes bits 10k+9:10k from its data bits 9:0, and bits 31:30 of the word are 0.
- R4: Format code 2 packs two samples per word: data bits 9:0 of the first sample go to word bits 9:0 and of the second to bits 25:16; bits 15:10 and 31:26 are 0.
- R5: Format code 3 packs two samples per word: data bits 15:0 of the first sample go to word bits 15:0 and of the second to bits 31:16.
- R6: Format code 4 makes one word per sample, data bits 19:0 in word bits 19:0 and bits 31:20 zero, valid in the cycle after each sample.
- R7: Sample data bits above the selected sample width do not appear in the word, and idle cycles between strobes do not disturb a partly filled word.
- R8: A cycle with flush_i high discards the partly filled word and any sample offered in that cycle; no word follows that cycle and the next sample taken starts a new word at the lowest field.
- R9: A cycle where fmt_i differs from its value in the previous cycle (the value during reset counts as code 0) acts like a flush: the partial word and that cycle's sample are discarded.
- R10: Format codes 5, 6 and 7 accept no sample and produce no word; chunk_words_o becomes 0 and chunk_ok_o 0.
- R11: One cycle after thrld_i and fmt_i are presented, chunk_words_o equals thrld_i divided by the samples per word of the format, rounded down.
- R12: One cycle after thrld_i and fmt_i are presented, chunk_ok_o is 1 exactly when that division leaves no remainder and gives a non-zero even word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Packing format code (0..4 valid) |
| flush_i | input | 1 | Discard partial word, restart at first field |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 20 | Sample data, right-justified |
| thrld_i | input | THR_W | Samples per threshold chunk |
| word_valid_o | output | 1 | Packed word valid, one-cycle pulse |
| word_data_o | output | 32 | Packed word |
| chunk_words_o | output | THR_W | Words per threshold chunk |
| chunk_ok_o | output | 1 | Threshold gives an exact, non-zero, even word count |

## Verification
A packed word is due in the cycle right after the clock edge that takes the last sample of the word, so the bench drives each sample after a falling edge and reads word_valid_o and word_data_o one nanosecond after the next rising edge, checking every sample cycle for either the absence or the presence of a word. Flush and format-change cycles are read the same way, one edge later, to confirm that no word leaks out and that the following word holds only fresh samples. The chunk length and its flag are registered once, so the bench presents a threshold and format before a rising edge and reads both results just after it.

// File: rtl/sample_packer_pkg.sv
package sample_packer_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SMP_W  = 20;

  localparam logic [2:0] FMT_8   = 3'd0;
  localparam logic [2:0] FMT_10D = 3'd1;
  localparam logic [2:0] FMT_10W = 3'd2;
  localparam logic [2:0] FMT_16  = 3'd3;
  localparam logic [2:0] FMT_20  = 3'd4;

  // samples per word; 0 marks an unsupported code
  function automatic logic [2:0] spw_of(input logic [2:0] fmt);
    case (fmt)
      FMT_8:           spw_of = 3'd4;
      FMT_10D:         spw_of = 3'd3;
      FMT_10W, FMT_16: spw_of = 3'd2;
      FMT_20:          spw_of = 3'd1;
      default:         spw_of = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/spk_lane_place.sv
module spk_lane_place
  import sample_packer_pkg::*;
(
  input  logic [2:0]        fmt_i,
  input  logic [1:0]        slot_i,
  input  logic [SMP_W-1:0]  data_i,
  output logic [WORD_W-1:0] placed_o
);
  logic [4:0] slot_w;
  assign slot_w = 5'(slot_i);

  always_comb begin
    case (fmt_i)
      FMT_8:   placed_o = WORD_W'(data_i[7:0])  << (slot_w * 5'd8);
      FMT_10D: placed_o = WORD_W'(data_i[9:0])  << (slot_w * 5'd10);
      FMT_10W: placed_o = WORD_W'(data_i[9:0])  << (slot_w * 5'd16);
      FMT_16:  placed_o = WORD_W'(data_i[15:0]) << (slot_w * 5'd16);
      FMT_20:  placed_o = WORD_W'(data_i[19:0]);
      default: placed_o = '0;
    endcase
  end
endmodule

// File: rtl/spk_slot_ctrl.sv
module spk_slot_ctrl
  import sample_packer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] fmt_i,
  input  logic       flush_i,
  input  logic       smp_valid_i,
  output logic [1:0] slot_o,
  output logic       accept_o,
  output logic       last_o
);
  logic [2:0] fmt_q;
  logic [1:0] slot_q;
  logic [2:0] spw;
  logic       restart;

  assign spw      = spw_of(fmt_i);
  assign restart  = flush_i | (fmt_i != fmt_q);
  assign accept_o = smp_valid_i & ~restart & (spw != 3'd0);
  assign last_o   = accept_o & (3'(slot_q) == spw - 3'd1);
  assign slot_o   = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_8;
      slot_q <= '0;
    end else begin
      fmt_q <= fmt_i;
      if (restart)       slot_q <= '0;
      else if (last_o)   slot_q <= '0;
      else if (accept_o) slot_q <= slot_q + 2'd1;
    end
  end
endmodule

// File: rtl/spk_chunk_calc.sv
module spk_chunk_calc
  import sample_packer_pkg::*;
#(
  parameter int unsigned THR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       fmt_i,
  input  logic [THR_W-1:0] thrld_i,
  output logic [THR_W-1:0] words_o,
  output logic             ok_o
);
  localparam logic [THR_W-1:0] DIV3 = THR_W'(3);

  logic [THR_W-1:0] quo;
  logic             rem_nz;

  always_comb begin
    case (spw_of(fmt_i))
      3'd4: begin quo = thrld_i >> 2;    rem_nz = |thrld_i[1:0];          end
      3'd3: begin quo = thrld_i / DIV3;  rem_nz = (thrld_i % DIV3) != '0; end
      3'd2: begin quo = thrld_i >> 1;    rem_nz = thrld_i[0];             end
      3'd1: begin quo = thrld_i;         rem_nz = 1'b0;                   end
      default: begin quo = '0;           rem_nz = 1'b1;                   end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_o <= '0;
      ok_o    <= 1'b0;
    end else begin
      words_o <= quo;
      ok_o    <= ~rem_nz & (quo != '0) & ~quo[0];
    end
  end
endmodule

// File: rtl/sample_word_packer.sv
module sample_word_packer
  import sample_packer_pkg::*;
#(
  parameter int unsigned THR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fmt_i,
  input  logic              flush_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  input  logic [THR_W-1:0]  thrld_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [THR_W-1:0]  chunk_words_o,
  output logic              chunk_ok_o
);
  logic [1:0]        slot;
  logic              accept;
  logic              last;
  logic [WORD_W-1:0] placed;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] merged;

  spk_slot_ctrl i_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt_i),
    .flush_i    (flush_i),
    .smp_valid_i(smp_valid_i),
    .slot_o     (slot),
    .accept_o   (accept),
    .last_o     (last)
  );

  spk_lane_place i_place (
    .fmt_i   (fmt_i),
    .slot_i  (slot),
    .data_i  (smp_data_i),
    .placed_o(placed)
  );

  spk_chunk_calc #(.THR_W(THR_W)) i_chunk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fmt_i  (fmt_i),
    .thrld_i(thrld_i),
    .words_o(chunk_words_o),
    .ok_o   (chunk_ok_o)
  );

  // slot 0 ignores stale accumulator contents, so no clear is needed on restart
  assign merged = ((slot == 2'd0) ? '0 : acc_q) | placed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      word_data_o  <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= last;
      if (accept) acc_q <= merged;
      if (last)   word_data_o <= merged;
    end
  end
endmodule

// File: rtl/spk_checker.sv
module spk_checker
  import sample_packer_pkg::*;
#(
  parameter int unsigned THR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        fmt_i,
  input logic              flush_i,
  input logic              smp_valid_i,
  input logic              word_valid_o,
  input logic [WORD_W-1:0] word_data_o,
  input logic [THR_W-1:0]  chunk_words_o,
  input logic              chunk_ok_o
);
  p_word_needs_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(smp_valid_i && !flush_i));

  p_dense_top_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && $past(fmt_i) == FMT_10D) |-> word_data_o[31:30] == 2'b00);

  p_wide10_gaps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && $past(fmt_i) == FMT_10W) |->
      (word_data_o[31:26] == 6'd0 && word_data_o[15:10] == 6'd0));

  p_20b_top_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && $past(fmt_i) == FMT_20) |-> word_data_o[31:20] == 12'd0);

  p_flush_no_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> !word_valid_o);

  p_bad_fmt_no_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fmt_i) > FMT_20) |-> !word_valid_o);

  p_chunk_ok_even_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_ok_o |-> (!chunk_words_o[0] && chunk_words_o != '0));
endmodule

bind sample_word_packer spk_checker #(.THR_W(THR_W)) i_spk_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fmt_i        (fmt_i),
  .flush_i      (flush_i),
  .smp_valid_i  (smp_valid_i),
  .word_valid_o (word_valid_o),
  .word_data_o  (word_data_o),
  .chunk_words_o(chunk_words_o),
  .chunk_ok_o   (chunk_ok_o)
);

// File: tb/test_sample_word_packer.sv
`timescale 1ns/1ps
module test_sample_word_packer;
  localparam int THR_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       fmt = 3'd0;
  logic             flush = 1'b0;
  logic             sv = 1'b0;
  logic [19:0]      sd = '0;
  logic [THR_W-1:0] thr = '0;
  logic             wv;
  logic [31:0]      wd;
  logic [THR_W-1:0] cw;
  logic             cok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sample_word_packer #(.THR_W(THR_W)) i_sample_word_packer (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .flush_i(flush),
    .smp_valid_i(sv), .smp_data_i(sd), .thrld_i(thr),
    .word_valid_o(wv), .word_data_o(wd),
    .chunk_words_o(cw), .chunk_ok_o(cok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // offer one sample, then check the output one edge later
  task automatic push(input string req, input logic [19:0] d,
                      input logic exp_v, input logic [31:0] exp_d);
    @(negedge clk);
    sv = 1'b1; sd = d;
    @(posedge clk); #1;
    sv = 1'b0;
    check({req, " valid"}, 32'(wv), 32'(exp_v));
    if (exp_v) check({req, " data"}, wd, exp_d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fmt(input logic [2:0] f);
    @(negedge clk); fmt = f;
    @(posedge clk); #1;
    check("R9 no word on format change", 32'(wv), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 reset valid", 32'(wv), 32'd0);
    check("R1 reset words", 32'(cw), 32'd0);
    check("R1 reset ok", 32'(cok), 32'd0);
  endtask

  task automatic t_8bit;
    push("R2 s0", 20'hABC11, 0, 0);
    push("R7 s1", 20'hFFF22, 0, 0);
    idle(2);
    push("R2 s2", 20'h00033, 0, 0);
    push("R2 s3", 20'h12344, 1, 32'h44332211);
    @(posedge clk); #1;
    check("R2 one-cycle pulse", 32'(wv), 32'd0);
  endtask

  task automatic t_dense;
    set_fmt(3'd1);
    push("R3 s0", 20'hFF3FF, 0, 0);
    push("R3 s1", 20'h00155, 0, 0);
    push("R3 s2", 20'hFFEAA, 1, (32'h2AA << 20) | (32'h155 << 10) | 32'h3FF);
    push("R3 top zero", 20'h003FF, 0, 0);
    push("R3 top zero", 20'h003FF, 0, 0);
    push("R3 top zero", 20'h003FF, 1, 32'h3FFFFFFF);
  endtask

  task automatic t_wide10;
    set_fmt(3'd2);
    push("R4 s0", 20'hFFFFF, 0, 0);
    push("R4 s1", 20'hFFC01, 1, 32'h000103FF);
  endtask

  task automatic t_16;
    set_fmt(3'd3);
    push("R5 s0", 20'hFBEEF, 0, 0);
    push("R5 s1", 20'h01234, 1, 32'h1234BEEF);
  endtask

  task automatic t_20;
    set_fmt(3'd4);
    push("R6 s0", 20'hFFFFF, 1, 32'h000FFFFF);
    push("R6 s1", 20'h5A5A5, 1, 32'h0005A5A5);
  endtask

  task automatic t_flush;
    set_fmt(3'd0);
    push("R8 pre0", 20'h000AA, 0, 0);
    push("R8 pre1", 20'h000BB, 0, 0);
    @(negedge clk); flush = 1'b1; sv = 1'b1; sd = 20'h000CC;
    @(posedge clk); #1;
    flush = 1'b0; sv = 1'b0;
    check("R8 no word after flush", 32'(wv), 32'd0);
    push("R8 n0", 20'h00001, 0, 0);
    push("R8 n1", 20'h00002, 0, 0);
    push("R8 n2", 20'h00003, 0, 0);
    push("R8 n3", 20'h00004, 1, 32'h04030201);
  endtask

  task automatic t_fmt_change;
    push("R9 pre0", 20'h00011, 0, 0);
    push("R9 pre1", 20'h00022, 0, 0);
    push("R9 pre2", 20'h00033, 0, 0);
    // change format with a sample in the same cycle: both partial and sample dropped
    @(negedge clk); fmt = 3'd3; sv = 1'b1; sd = 20'h0AAAA;
    @(posedge clk); #1;
    sv = 1'b0;
    check("R9 no word at change", 32'(wv), 32'd0);
    push("R9 n0", 20'h05555, 0, 0);
    push("R9 n1", 20'h06666, 1, 32'h66665555);
  endtask

  task automatic t_bad_fmt;
    set_fmt(3'd5);
    push("R10 s0", 20'h00001, 0, 0);
    push("R10 s1", 20'h00002, 0, 0);
    push("R10 s2", 20'h00003, 0, 0);
    push("R10 s3", 20'h00004, 0, 0);
    push("R10 s4", 20'h00005, 0, 0);
    @(negedge clk); thr = 12'd96; fmt = 3'd7;
    @(posedge clk); #1;
    check("R10 words", 32'(cw), 32'd0);
    check("R10 ok", 32'(cok), 32'd0);
  endtask

  task automatic chunk(input logic [2:0] f, input logic [THR_W-1:0] t,
                       input logic [THR_W-1:0] exp_w, input logic exp_ok);
    @(negedge clk); fmt = f; thr = t;
    @(posedge clk); #1;
    check("R11 chunk words", 32'(cw), 32'(exp_w));
    check("R12 chunk ok", 32'(cok), 32'(exp_ok));
  endtask

  task automatic t_chunk;
    chunk(3'd0, 12'd96, 12'd24, 1);
    chunk(3'd1, 12'd96, 12'd32, 1);
    chunk(3'd2, 12'd96, 12'd48, 1);
    chunk(3'd3, 12'd96, 12'd48, 1);
    chunk(3'd4, 12'd96, 12'd96, 1);
    chunk(3'd1, 12'd12, 12'd4, 1);
    chunk(3'd1, 12'd9, 12'd3, 0);
    chunk(3'd1, 12'd13, 12'd4, 0);
    chunk(3'd0, 12'd10, 12'd2, 0);
    chunk(3'd4, 12'd0, 12'd0, 0);
    chunk(3'd1, 12'd4095, 12'd1365, 0);
    chunk(3'd1, 12'd4092, 12'd1364, 1);
  endtask

  initial begin
    #1;
    t_reset();
    #20;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_8bit();
    t_dense();
    t_wide10();
    t_16();
    t_20();
    t_flush();
    t_fmt_change();
    t_bad_fmt();
    t_chunk();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule